// File: doc/BRIEF.md
# Square Wave Tone Channel

This block is one programmable square-wave voice for a sound subsystem. An 11-bit frequency value sets the rate of an eight-step duty sequencer. A 2-bit selector picks one of four fixed waveforms. The output is a 4-bit amplitude that follows the current envelope volume while the waveform is high and the channel is active.

Three slow processes shape each note. A frequency sweep unit moves the pitch up or down by a shifted fraction of itself, and it silences the channel if the result leaves the 11-bit range. A volume envelope ramps the level up or down, clamped at 0 and 15. A length counter can stop the note after a programmed number of ticks.

The three processes are paced by single-cycle strobes from an external frame sequencer. The length strobe runs at 256 Hz, the sweep strobe at 128 Hz and the envelope strobe at 64 Hz. Software reaches the voice through five byte-wide registers on a plain write/read bus. An instance built with `HAS_SWEEP = 0` drops the sweep unit and its register, and serves as the second voice.

Top module: `sqr_voice`

## Requirements
- R1: After reset, `active` is 0, `amp` is 0, and every register address reads 0.
- R2: Register addresses and readback formats are as follows.
  - Address 0 (sweep): reads `{0, period[2:0], direction, shift[2:0]}`.
  - Address 1 (duty/length): reads the duty in bits 7-6, with 0 in the other bits.
  - Address 2 (envelope): reads back as written.
  - Address 3: reads the low 8 bits of the current frequency.
  - Address 4 (control): reads `{0, length-enable, 000, frequency[10:8]}`. The restart bit always reads 0.
- R3: The duty step advances once every (2048 − f) × 4 clock cycles, where f is the 11-bit frequency. A restart (a control write with bit 7 set) returns the step to 0 and reloads the timer from the frequency in that same write.
- R4: The duty select is bits 7-6 of address 1. The waveform is high on these steps:
  - 00: step 7 only.
  - 01: steps 0 and 7.
  - 10: steps 0, 5, 6 and 7.
  - 11: steps 1 through 6.
- R5: `amp` equals the envelope volume when the channel is active and the waveform is high. Otherwise `amp` is 0.
- R6: Envelope register fields: bits 7-4 are the initial volume, bit 3 is the direction (1 = up, 0 = down), and bits 2-0 are the step period.
  - A restart loads the volume from bits 7-4.
  - A restart sets `active` only if envelope bits 7-3 are not all zero.
  - Writing the envelope with bits 7-3 all zero clears `active` at that edge.
- R7: While the channel is active, the volume moves one step toward the chosen direction on every p-th envelope tick after a restart, where p is the step period. The volume saturates at 0 and 15. With p = 0 the volume stays frozen.
- R8: A write to address 1 loads the length counter with 64 − L, where L is bits 5-0. While control bit 6 is set, each length tick decrements the counter, and the tick that brings it to 0 clears `active`. While bit 6 is clear, length ticks have no effect.
- R9: A restart reloads an expired (zero) length counter to 64. A restart leaves a non-zero length counter unchanged.
- R10: Sweep register fields: bits 6-4 are the period p, bit 3 is the direction (0 = add, 1 = subtract), and bits 2-0 are the shift n.
  - A restart copies the frequency into a shadow register.
  - While the channel is active, every p-th sweep tick computes shadow ± (shadow >> n).
  - If n ≠ 0 and the result is at most 2047, the result is written to both the shadow and the frequency.
  - With p = 0 no sweep update happens.
- R11: A sweep calculation whose result exceeds 2047 clears `active` and leaves the frequency unchanged. This applies even when n = 0.
- R12: With `HAS_SWEEP = 0`, address 0 reads 0, writes to it are ignored, and sweep ticks never change the frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address, 0 to 4 |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from `bus_addr`) |
| tick_len | input | 1 | Length tick strobe (256 Hz) |
| tick_sweep | input | 1 | Sweep tick strobe (128 Hz) |
| tick_env | input | 1 | Envelope tick strobe (64 Hz) |
| amp | output | 4 | Output amplitude |
| active | output | 1 | Channel-active flag |

## Verification
The failure modes show up at the ports with different delays:
- A corrupted duty step or frequency timer shows up on `amp` within one step period, as a high or low phase in the wrong place.
- A wrong volume shows up on the very next high phase.
- A length counter or sweep shadow that has drifted stays hidden until its tick. It then shows as `active` falling one tick early or late, or as a wrong frequency read back after the sweep tick that should have written it.

Because of that last case, the bench reads back state after every tick instead of only at the end of a note.

// File: rtl/sqr_pkg.sv
`timescale 1ns/1ps
package sqr_pkg;
  localparam int FREQ_W  = 11;
  localparam int VOL_W   = 4;
  localparam int LEN_W   = 6;
  localparam int PER_W   = 3;
  localparam int STEP_W  = 3;
  localparam int CLK_MUL = 4;
  localparam int TMR_W   = FREQ_W + $clog2(CLK_MUL);

  typedef enum logic [2:0] {
    REG_SWEEP   = 3'd0,
    REG_LENDUTY = 3'd1,
    REG_ENV     = 3'd2,
    REG_FLO     = 3'd3,
    REG_CTRL    = 3'd4
  } reg_sel_e;

  // Timer load value: one step lasts (2^FREQ_W - f) * CLK_MUL clocks.
  function automatic logic [TMR_W-1:0] timer_reload(input logic [FREQ_W-1:0] f);
    logic [TMR_W:0] span;
    span = (TMR_W+1)'(2**FREQ_W) - {{(TMR_W+1-FREQ_W){1'b0}}, f};
    span = span * (TMR_W+1)'(CLK_MUL);
    return TMR_W'(span - 1'b1);
  endfunction

  // Waveform bit for a duty select and a sequencer step.
  function automatic logic duty_high(input logic [1:0] sel, input logic [STEP_W-1:0] s);
    logic [7:0] w;
    case (sel)
      2'd0:    w = 8'b1000_0000;
      2'd1:    w = 8'b1000_0001;
      2'd2:    w = 8'b1110_0001;
      default: w = 8'b0111_1110;
    endcase
    return w[s];
  endfunction

  // Sweep arithmetic; the top bit flags a result past the frequency range.
  function automatic logic [FREQ_W:0] sweep_next(input logic [FREQ_W-1:0] sh,
                                                 input logic [PER_W-1:0] n,
                                                 input logic down);
    logic [FREQ_W:0] base;
    logic [FREQ_W:0] delta;
    base  = {1'b0, sh};
    delta = base >> n;
    return down ? (base - delta) : (base + delta);
  endfunction
endpackage

// File: rtl/sqr_freq_timer.sv
`timescale 1ns/1ps
module sqr_freq_timer
  import sqr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [FREQ_W-1:0] freq,
  output logic [STEP_W-1:0] step,
  output logic              adv
);
  logic [TMR_W-1:0] cnt;

  assign adv = !trig && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      step <= '0;
    end else if (trig) begin
      cnt  <= timer_reload(freq);
      step <= '0;
    end else if (cnt == '0) begin
      cnt  <= timer_reload(freq);
      step <= step + 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sqr_envelope.sv
`timescale 1ns/1ps
module sqr_envelope
  import sqr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             active,
  input  logic             tick,
  input  logic [VOL_W-1:0] init,
  input  logic             up,
  input  logic [PER_W-1:0] per,
  output logic [VOL_W-1:0] vol,
  output logic             step_evt
);
  localparam logic [VOL_W-1:0] VMAX = '1;
  logic [PER_W-1:0] tmr;
  logic             run;
  logic             fire;

  assign run      = tick && active && !trig && (per != '0);
  assign fire     = run && (tmr <= PER_W'(1));
  assign step_evt = fire && (up ? (vol != VMAX) : (vol != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol <= '0;
      tmr <= '0;
    end else if (trig) begin
      vol <= init;
      tmr <= per;
    end else if (run) begin
      tmr <= fire ? per : tmr - 1'b1;
      if (step_evt) vol <= up ? vol + 1'b1 : vol - 1'b1;
    end
  end
endmodule

// File: rtl/sqr_length.sv
`timescale 1ns/1ps
module sqr_length
  import sqr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             trig,
  input  logic             tick,
  input  logic             en,
  output logic             expire
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(2**LEN_W);
  logic [CNT_W-1:0] cnt;

  assign expire = tick && en && !load && !trig && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= FULL - {1'b0, load_val};
    end else if (trig) begin
      if (cnt == '0) cnt <= FULL;
    end else if (tick && en && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sqr_sweep.sv
`timescale 1ns/1ps
module sqr_sweep
  import sqr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              active,
  input  logic              tick,
  input  logic [PER_W-1:0]  per,
  input  logic              down,
  input  logic [PER_W-1:0]  shift,
  input  logic [FREQ_W-1:0] freq_load,
  output logic              upd,
  output logic              ovf,
  output logic [FREQ_W-1:0] new_freq
);
  logic [FREQ_W-1:0] shadow;
  logic [PER_W-1:0]  tmr;
  logic [FREQ_W:0]   calc;
  logic              run;
  logic              fire;

  assign calc     = sweep_next(shadow, shift, down);
  assign run      = tick && active && !trig && (per != '0);
  assign fire     = run && (tmr <= PER_W'(1));
  assign ovf      = fire && calc[FREQ_W];
  assign upd      = fire && !calc[FREQ_W] && (shift != '0);
  assign new_freq = calc[FREQ_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      tmr    <= '0;
    end else if (trig) begin
      shadow <= freq_load;
      tmr    <= per;
    end else begin
      if (run) tmr <= fire ? per : tmr - 1'b1;
      if (upd) shadow <= new_freq;
    end
  end
endmodule

// File: rtl/sqr_voice.sv
`timescale 1ns/1ps
module sqr_voice
  import sqr_pkg::*;
#(
  parameter bit HAS_SWEEP = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             tick_len,
  input  logic             tick_sweep,
  input  logic             tick_env,
  output logic [VOL_W-1:0] amp,
  output logic             active
);
  localparam int HI_W = FREQ_W - 8;

  // Programmed fields
  logic [PER_W-1:0]  sw_per;
  logic              sw_down;
  logic [PER_W-1:0]  sw_shift;
  logic [1:0]        duty;
  logic [VOL_W-1:0]  env_init;
  logic              env_up;
  logic [PER_W-1:0]  env_per;
  logic [FREQ_W-1:0] freq;
  logic              len_en;

  // Named internal events
  logic wr_sweep, wr_lendut, wr_env, wr_flo, wr_ctrl;
  logic trig, freq_wr, dac_on, kill;
  logic duty_adv, env_step, len_expire, sweep_upd, sweep_ovf;
  logic [FREQ_W-1:0] sweep_freq, freq_ld;
  logic [STEP_W-1:0] step;
  logic [VOL_W-1:0]  vol;

  assign wr_sweep  = bus_wr && (bus_addr == REG_SWEEP) && HAS_SWEEP;
  assign wr_lendut = bus_wr && (bus_addr == REG_LENDUTY);
  assign wr_env    = bus_wr && (bus_addr == REG_ENV);
  assign wr_flo    = bus_wr && (bus_addr == REG_FLO);
  assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
  assign trig      = wr_ctrl && bus_wdata[7];
  assign freq_wr   = wr_flo || wr_ctrl;
  assign freq_ld   = trig ? {bus_wdata[HI_W-1:0], freq[7:0]} : freq;
  assign dac_on    = ({env_init, env_up} != '0);
  assign kill      = len_expire || sweep_ovf || (wr_env && (bus_wdata[7:3] == 5'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_per   <= '0;
      sw_down  <= 1'b0;
      sw_shift <= '0;
      duty     <= '0;
      env_init <= '0;
      env_up   <= 1'b0;
      env_per  <= '0;
      freq     <= '0;
      len_en   <= 1'b0;
      active   <= 1'b0;
    end else begin
      if (wr_sweep)  {sw_per, sw_down, sw_shift} <= bus_wdata[6:0];
      if (wr_lendut) duty <= bus_wdata[7:6];
      if (wr_env)    {env_init, env_up, env_per} <= bus_wdata;
      if (wr_ctrl)   len_en <= bus_wdata[6];
      if (wr_flo)    freq[7:0] <= bus_wdata;
      if (wr_ctrl)   freq[FREQ_W-1:8] <= bus_wdata[HI_W-1:0];
      if (!freq_wr && sweep_upd) freq <= sweep_freq;
      if (trig)      active <= dac_on;
      else if (kill) active <= 1'b0;
    end
  end

  sqr_freq_timer u_timer (
    .clk(clk), .rst_n(rst_n), .trig(trig), .freq(freq_ld),
    .step(step), .adv(duty_adv)
  );

  sqr_envelope u_env (
    .clk(clk), .rst_n(rst_n), .trig(trig), .active(active), .tick(tick_env),
    .init(env_init), .up(env_up), .per(env_per),
    .vol(vol), .step_evt(env_step)
  );

  sqr_length u_len (
    .clk(clk), .rst_n(rst_n), .load(wr_lendut), .load_val(bus_wdata[LEN_W-1:0]),
    .trig(trig), .tick(tick_len), .en(len_en), .expire(len_expire)
  );

  generate
    if (HAS_SWEEP) begin : g_sweep
      sqr_sweep u_sweep (
        .clk(clk), .rst_n(rst_n), .trig(trig), .active(active), .tick(tick_sweep),
        .per(sw_per), .down(sw_down), .shift(sw_shift), .freq_load(freq_ld),
        .upd(sweep_upd), .ovf(sweep_ovf), .new_freq(sweep_freq)
      );
    end else begin : g_nosweep
      assign sweep_upd  = 1'b0;
      assign sweep_ovf  = 1'b0;
      assign sweep_freq = '0;
    end
  endgenerate

  assign amp = (active && duty_high(duty, step)) ? vol : '0;

  always_comb begin
    case (bus_addr)
      REG_SWEEP:   bus_rdata = HAS_SWEEP ? {1'b0, sw_per, sw_down, sw_shift} : 8'h00;
      REG_LENDUTY: bus_rdata = {duty, 6'b0};
      REG_ENV:     bus_rdata = {env_init, env_up, env_per};
      REG_FLO:     bus_rdata = freq[7:0];
      REG_CTRL:    bus_rdata = {1'b0, len_en, {(6-HI_W){1'b0}}, freq[FREQ_W-1:8]};
      default:     bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/sqr_voice_chk.sv
`timescale 1ns/1ps
module sqr_voice_chk
  import sqr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              active,
  input logic [VOL_W-1:0]  amp,
  input logic [VOL_W-1:0]  vol,
  input logic [STEP_W-1:0] step,
  input logic              duty_adv,
  input logic              env_step,
  input logic              len_expire,
  input logic              sweep_ovf,
  input logic              sweep_upd,
  input logic [FREQ_W-1:0] freq,
  input logic              freq_wr
);
  assert_silent_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (amp == '0));

  assert_amp_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (amp != '0) |-> (amp == vol));

  assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!duty_adv && !trig) |=> $stable(step));

  assert_vol_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!env_step && !trig) |=> $stable(vol));

  assert_len_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    len_expire |=> !active);

  assert_ovf_kill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_ovf |=> !active);

  assert_freq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!freq_wr && !sweep_upd) |=> $stable(freq));
endmodule

bind sqr_voice sqr_voice_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .active(active), .amp(amp), .vol(vol),
  .step(step), .duty_adv(duty_adv), .env_step(env_step), .len_expire(len_expire),
  .sweep_ovf(sweep_ovf), .sweep_upd(sweep_upd), .freq(freq), .freq_wr(freq_wr)
);

// File: tb/tb_sqr_voice.sv
`timescale 1ns/1ps
module tb_sqr_voice;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       tick_len = 1'b0, tick_sweep = 1'b0, tick_env = 1'b0;
  logic [7:0] rdata, rdata_ns;
  logic [3:0] amp, amp_ns;
  logic       active, active_ns;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  sqr_voice dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .tick_len(tick_len),
    .tick_sweep(tick_sweep), .tick_env(tick_env), .amp(amp), .active(active)
  );

  sqr_voice #(.HAS_SWEEP(1'b0)) dut_ns (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_ns), .tick_len(tick_len),
    .tick_sweep(tick_sweep), .tick_env(tick_env), .amp(amp_ns), .active(active_ns)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tk(input int which);
    tick_len = (which == 0); tick_sweep = (which == 1); tick_env = (which == 2);
    @(posedge clk); @(negedge clk);
    tick_len = 1'b0; tick_sweep = 1'b0; tick_env = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v, output logic [7:0] vns);
    bus_addr = a; #1;
    v = rdata; vns = rdata_ns;
  endtask

  function automatic bit wave_hi(input int d, input int s);
    case (d)
      0:       return s == 7;
      1:       return (s == 0) || (s == 7);
      2:       return (s == 0) || (s > 4);
      default: return (s > 0) && (s < 7);
    endcase
  endfunction

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, vns, v4, v4ns;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 active", active, 0);
    check("R1 amp", amp, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v, vns);
      check("R1 read", v, 0);
      check("R1 read ns", vns, 0);
    end

    // R2: readback formats
    wr(1, 8'hBF); rd(1, v, vns); check("R2 duty read", v, 8'h80);
    wr(2, 8'h5A); rd(2, v, vns); check("R2 env read", v, 8'h5A);
    wr(3, 8'h3C); rd(3, v, vns); check("R2 flo read", v, 8'h3C);
    wr(4, 8'hC5); rd(4, v, vns); check("R2 ctrl read", v, 8'h45);

    // R3, R4, R5: duty waveforms at several step periods
    wr(2, 8'hF0);
    for (int d = 0; d < 4; d++) begin
      for (int fi = 0; fi < 4; fi++) begin
        int f;
        int p;
        f = 2048 - (1 << fi);
        p = (2048 - f) * 4;
        wr(1, 8'(d << 6));
        wr(3, 8'(f & 255));
        wr(4, 8'(8'h80 | (f >> 8)));
        for (int n = 0; n < 8 * p; n++) begin
          check("R3,R4,R5 wave", amp, wave_hi(d, (n / p) % 8) ? 15 : 0);
          @(negedge clk);
        end
      end
    end

    // R6, R7: envelope over all volumes, both directions, three periods
    wr(3, 8'h00); wr(1, 8'h40);
    for (int iv = 0; iv < 16; iv++) begin
      for (int up = 0; up < 2; up++) begin
        for (int pi = 0; pi < 3; pi++) begin
          int per;
          bit on;
          per = (pi == 2) ? 3 : pi;
          on  = (iv != 0) || (up != 0);
          wr(2, 8'((iv << 4) | (up << 3) | per));
          wr(4, 8'h80);
          check("R6 start active", active, on);
          check("R6 start amp", amp, on ? iv : 0);
          for (int k = 1; k <= 18; k++) begin
            int e;
            tk(2);
            if (per == 0) e = iv;
            else if (up != 0) e = (iv + k / per > 15) ? 15 : iv + k / per;
            else e = (iv - k / per < 0) ? 0 : iv - k / per;
            check("R7 volume", amp, on ? e : 0);
          end
        end
      end
    end
    wr(2, 8'hF0); wr(4, 8'h80);
    check("R6 on", active, 1);
    wr(2, 8'h00);
    check("R6 env off", active, 0);
    check("R6 env off amp", amp, 0);

    // R8: length expiry
    wr(2, 8'hF0);
    for (int li = 0; li < 4; li++) begin
      int len;
      len = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 40 : 63;
      wr(1, 8'(8'h40 | len));
      wr(4, 8'hC0);
      for (int i = 0; i < 63 - len; i++) tk(0);
      check("R8 before expiry", active, 1);
      tk(0);
      check("R8 expired", active, 0);
    end
    // R9: restart after expiry gives a full 64 ticks
    wr(4, 8'hC0);
    for (int i = 0; i < 63; i++) tk(0);
    check("R9 reload 63", active, 1);
    tk(0);
    check("R9 reload 64", active, 0);
    // R8: length disabled ignores ticks
    wr(1, 8'h40 | 8'd60);
    wr(4, 8'h80);
    for (int i = 0; i < 10; i++) tk(0);
    check("R8 disabled active", active, 1);
    check("R8 disabled amp", amp, 15);

    // R10, R11, R12: sweep over all shifts, both directions, three periods
    wr(1, 8'h40); wr(2, 8'hF0);
    for (int per = 0; per < 3; per++) begin
      for (int dn = 0; dn < 2; dn++) begin
        for (int sh = 0; sh < 8; sh++) begin
          for (int fi = 0; fi < 2; fi++) begin
            int f0;
            int mf;
            bit ma;
            f0 = (fi != 0) ? 1443 : 256;
            wr(0, 8'((per << 4) | (dn << 3) | sh));
            rd(0, v, vns);
            check("R2 sweep read", v, (per << 4) | (dn << 3) | sh);
            check("R12 sweep read ns", vns, 0);
            wr(3, 8'(f0 & 255));
            wr(4, 8'(8'h80 | (f0 >> 8)));
            mf = f0; ma = 1'b1;
            for (int k = 1; k <= 10; k++) begin
              tk(1);
              if (ma && per != 0 && (k % per) == 0) begin
                int c;
                c = (dn != 0) ? mf - (mf >> sh) : mf + (mf >> sh);
                if (c > 2047) ma = 1'b0;
                else if (sh != 0) mf = c;
              end
              rd(3, v, vns); rd(4, v4, v4ns);
              check("R10 freq", {v4[2:0], v}, mf);
              check("R11 active", active, ma);
            end
            rd(3, v, vns); rd(4, v4, v4ns);
            check("R12 freq ns", {v4ns[2:0], vns}, f0);
          end
        end
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule